// File: doc/BRIEF.md
# PRBS Test Pattern Engine

This block sends and checks pseudo-random test bit sequences on a serial bit stream at the line side. It has two paths. On the transmit path, bits pass through unchanged. When the transmit enable is set, the outgoing bits are replaced by a generated pseudo-random sequence. On the receive path, a monitor aligns itself to the incoming sequence and shows whether it is in sync. It counts bit errors while in sync, and it raises an interrupt each time the sync state changes.

A small control register selects the features:

| Bit | Field | Meaning |
|-----|-------|---------|
| 0 | tx_en | replace transmit data with the sequence |
| 1 | mon_en | enable the monitor |
| 2 | pat_long | select the 20-bit pattern; the 15-bit pattern otherwise |
| 3 | stat_sel | drive the sync status onto its pin |

The pattern select applies to both paths. Single-cycle strobes clear the error counter and the interrupt flag.

Both bit streams use valid/ready handshakes:
- **Transmit.** The path has no storage. `tx_out_valid` follows `tx_in_valid` and `tx_in_ready` follows `tx_out_ready` in the same cycle. A beat is accepted only when valid and ready are both high. While the sink holds ready low, the input is stalled and the generator holds its state.
- **Receive.** `rx_ready` is always high, so the monitor never applies back-pressure. A received bit counts only in cycles where `rx_valid` is high.

Top module: `prbs_test_engine`

## Requirements
- R1: After reset, the control register (tx_en=bit0, mon_en=bit1, pat_long=bit2, stat_sel=bit3) reads 0, and `mon_sync`, `sync_pin`, `irq` and `err_count` are all 0.
- R2: `tx_out_valid` equals `tx_in_valid` and `tx_in_ready` equals `tx_out_ready` in the same cycle. With tx_en clear, `tx_out_bit` equals `tx_in_bit`.
- R3: With tx_en set, `tx_out_bit` is the feedback bit of a 20-bit state register. The feedback is s[14]^s[13] for the short pattern (x^15+x^14+1) and s[19]^s[16] for the long pattern (x^20+x^17+1). On each accepted transmit beat the state shifts left and takes the feedback bit into bit 0. The state is reloaded to all ones whenever tx_en is clear.
- R4: The monitor uses the same feedback rule to predict each received bit. While hunting, it shifts in the received bits and declares sync after 32 consecutive correct predictions made from a nonzero register. A clean sequence is in sync after at most (pattern length + 32) bits, and never after only 31 bits. An all-zero input never brings it into sync.
- R5: While in sync, the monitor runs on its own prediction. If a mismatching bit brings the errors within the last 64 received bits to 6, the monitor leaves sync on that bit and reloads from the input. Five errors in every 64-bit window keep it in sync.
- R6: Each received bit that mismatches while the monitor is enabled and in sync increments `err_count` by exactly 1. Mismatches while hunting are not counted.
- R7: `err_count` saturates at 2^ERR_CNT_W-1 (0xFFFF by default).
- R8: `cnt_clr` clears `err_count`. If an error is counted in the same cycle, the result is 1.
- R9: With mon_en clear, the monitor is out of sync and `err_count` does not change.
- R10: `irq` is set on the clock edge where `mon_sync` changes in either direction. It stays set until `irq_clr`. When a clear and a change of sync state fall in the same cycle, `irq` remains set.
- R11: `sync_pin` is high exactly when `mon_sync`, stat_sel and mon_en are all set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| cfg_we | input | 1 | control register write strobe |
| cfg_wdata | input | 4 | control register write data |
| cfg_q | output | 4 | control register contents |
| irq_clr | input | 1 | clears the interrupt flag |
| cnt_clr | input | 1 | clears the error counter |
| tx_in_valid | input | 1 | transmit input beat valid |
| tx_in_ready | output | 1 | transmit input ready |
| tx_in_bit | input | 1 | transmit input data bit |
| tx_out_valid | output | 1 | transmit output beat valid |
| tx_out_ready | input | 1 | transmit output ready from the sink |
| tx_out_bit | output | 1 | transmit output data bit |
| rx_valid | input | 1 | received bit valid |
| rx_ready | output | 1 | constant high |
| rx_bit | input | 1 | received data bit |
| mon_sync | output | 1 | monitor sync status |
| sync_pin | output | 1 | gated sync status pin |
| err_count | output | ERR_CNT_W | bit error count |
| irq | output | 1 | sync-change interrupt flag |

## Verification
The transmit handshake and output bit are combinational, so the bench checks them 1 ns after driving each beat. The generator state moves to its next value at the following edge, and the bench's model advances at the same point. Monitor results are registered: `mon_sync`, `irq` and `err_count` reflect a received bit or strobe one edge after it is presented. Because the bench drives each bit at a falling edge, it reads these outputs at the next falling edge. The same-cycle cases (clear against error, clear against sync loss) are lined up so that both stimuli fall before the same rising edge.

// File: rtl/prbs_pkg.sv
package prbs_pkg;

  localparam int LFSR_W    = 20;
  localparam int SHORT_LEN = 15;
  localparam int SHORT_TAP = 14;
  localparam int LONG_LEN  = 20;
  localparam int LONG_TAP  = 17;
  localparam logic [LFSR_W-1:0] SEED = '1;

  typedef struct packed {
    logic stat_sel;
    logic pat_long;
    logic mon_en;
    logic tx_en;
  } prbs_cfg_t;

  function automatic logic prbs_fb(input logic [LFSR_W-1:0] s, input logic long_sel);
    if (long_sel) return s[LONG_LEN-1] ^ s[LONG_TAP-1];
    return s[SHORT_LEN-1] ^ s[SHORT_TAP-1];
  endfunction

  function automatic logic [LFSR_W-1:0] prbs_mask(input logic long_sel);
    logic [LFSR_W-1:0] m;
    for (int i = 0; i < LFSR_W; i++) m[i] = long_sel ? (i < LONG_LEN) : (i < SHORT_LEN);
    return m;
  endfunction

endpackage

// File: rtl/prbs_tx_gen.sv
module prbs_tx_gen
  import prbs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic long_sel,
  input  logic advance,
  output logic bit_o
);

  logic [LFSR_W-1:0] state_q;
  logic [LFSR_W-1:0] state_nxt;

  assign bit_o = prbs_fb(state_q, long_sel);

  always_comb begin
    state_nxt = {state_q[LFSR_W-2:0], bit_o};
    if ((state_nxt & prbs_mask(long_sel)) == '0) state_nxt = SEED;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) state_q <= SEED;
    else if (advance)      state_q <= state_nxt;
  end

endmodule

// File: rtl/prbs_rx_mon.sv
module prbs_rx_mon
  import prbs_pkg::*;
#(
  parameter int SYNC_RUN  = 32,
  parameter int WIN_LEN   = 64,
  parameter int LOSS_ERRS = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic long_sel,
  input  logic bit_valid,
  input  logic bit_i,
  output logic in_sync,
  output logic sync_chg,
  output logic err_pulse
);

  localparam int RUN_W = $clog2(SYNC_RUN + 1);
  localparam int WC_W  = $clog2(WIN_LEN + 1);

  logic [LFSR_W-1:0]  state_q, state_d;
  logic [RUN_W-1:0]   run_q, run_d;
  logic [WIN_LEN-1:0] hist_q, hist_d;
  logic [WC_W-1:0]    win_q, win_d, win_sum;
  logic               sync_q, sync_d;
  logic               pred, mism, nonzero;

  assign pred    = prbs_fb(state_q, long_sel);
  assign mism    = bit_i != pred;
  assign nonzero = |(state_q & prbs_mask(long_sel));
  assign win_sum = win_q - WC_W'(hist_q[WIN_LEN-1]) + WC_W'(mism);

  always_comb begin
    state_d = state_q;
    run_d   = run_q;
    hist_d  = hist_q;
    win_d   = win_q;
    sync_d  = sync_q;
    if (!enable) begin
      state_d = '0;
      run_d   = '0;
      hist_d  = '0;
      win_d   = '0;
      sync_d  = 1'b0;
    end else if (bit_valid) begin
      if (!sync_q) begin
        state_d = {state_q[LFSR_W-2:0], bit_i};
        if (!mism && nonzero) begin
          if (run_q == RUN_W'(SYNC_RUN - 1)) begin
            sync_d = 1'b1;
            run_d  = '0;
            hist_d = '0;
            win_d  = '0;
          end else begin
            run_d = run_q + 1'b1;
          end
        end else begin
          run_d = '0;
        end
      end else begin
        state_d = {state_q[LFSR_W-2:0], pred};
        hist_d  = {hist_q[WIN_LEN-2:0], mism};
        win_d   = win_sum;
        if (mism && win_sum >= WC_W'(LOSS_ERRS)) begin
          sync_d  = 1'b0;
          state_d = '0;
          run_d   = '0;
          hist_d  = '0;
          win_d   = '0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= '0;
      run_q   <= '0;
      hist_q  <= '0;
      win_q   <= '0;
      sync_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      run_q   <= run_d;
      hist_q  <= hist_d;
      win_q   <= win_d;
      sync_q  <= sync_d;
    end
  end

  assign in_sync   = sync_q;
  assign sync_chg  = sync_d != sync_q;
  assign err_pulse = enable && bit_valid && sync_q && mism;

endmodule

// File: rtl/prbs_err_cnt.sv
module prbs_err_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             clr,
  output logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk) begin
    if (!rst_n)                     count <= '0;
    else if (clr)                   count <= inc ? CNT_W'(1) : '0;
    else if (inc && count != CNT_MAX) count <= count + 1'b1;
  end

endmodule

// File: rtl/prbs_test_engine.sv
module prbs_test_engine
  import prbs_pkg::*;
#(
  parameter int ERR_CNT_W = 16,
  parameter int SYNC_RUN  = 32,
  parameter int WIN_LEN   = 64,
  parameter int LOSS_ERRS = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [3:0]           cfg_wdata,
  output logic [3:0]           cfg_q,
  input  logic                 irq_clr,
  input  logic                 cnt_clr,
  input  logic                 tx_in_valid,
  output logic                 tx_in_ready,
  input  logic                 tx_in_bit,
  output logic                 tx_out_valid,
  input  logic                 tx_out_ready,
  output logic                 tx_out_bit,
  input  logic                 rx_valid,
  output logic                 rx_ready,
  input  logic                 rx_bit,
  output logic                 mon_sync,
  output logic                 sync_pin,
  output logic [ERR_CNT_W-1:0] err_count,
  output logic                 irq
);

  prbs_cfg_t cfg_r;
  logic      gen_bit, sync_chg, err_pulse;

  always_ff @(posedge clk) begin
    if (!rst_n)      cfg_r <= '0;
    else if (cfg_we) cfg_r <= prbs_cfg_t'(cfg_wdata);
  end
  assign cfg_q = cfg_r;

  assign tx_out_valid = tx_in_valid;
  assign tx_in_ready  = tx_out_ready;
  assign tx_out_bit   = cfg_r.tx_en ? gen_bit : tx_in_bit;
  assign rx_ready     = 1'b1;

  prbs_tx_gen i_gen (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (cfg_r.tx_en),
    .long_sel (cfg_r.pat_long),
    .advance  (tx_in_valid && tx_out_ready),
    .bit_o    (gen_bit)
  );

  prbs_rx_mon #(
    .SYNC_RUN  (SYNC_RUN),
    .WIN_LEN   (WIN_LEN),
    .LOSS_ERRS (LOSS_ERRS)
  ) i_mon (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (cfg_r.mon_en),
    .long_sel  (cfg_r.pat_long),
    .bit_valid (rx_valid),
    .bit_i     (rx_bit),
    .in_sync   (mon_sync),
    .sync_chg  (sync_chg),
    .err_pulse (err_pulse)
  );

  prbs_err_cnt #(.CNT_W(ERR_CNT_W)) i_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (err_pulse),
    .clr   (cnt_clr),
    .count (err_count)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)        irq <= 1'b0;
    else if (sync_chg) irq <= 1'b1;
    else if (irq_clr)  irq <= 1'b0;
  end

  assign sync_pin = mon_sync && cfg_r.stat_sel && cfg_r.mon_en;

endmodule

// File: rtl/prbs_test_engine_chk.sv
module prbs_test_engine_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [3:0]       cfg_q,
  input logic             irq_clr,
  input logic             cnt_clr,
  input logic             rx_valid,
  input logic             mon_sync,
  input logic             sync_pin,
  input logic [CNT_W-1:0] err_count,
  input logic             irq
);

  p_pin_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
    sync_pin |-> (mon_sync && cfg_q[3] && cfg_q[1]));

  p_off_nosync_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_q[1] |=> !mon_sync);

  p_off_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_q[1] && !cnt_clr) |=> $stable(err_count));

  p_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_clr |=> (err_count == $past(err_count) || err_count == $past(err_count) + 1));

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (err_count == {CNT_W{1'b1}} && !cnt_clr) |=> err_count == {CNT_W{1'b1}});

  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |=> err_count <= CNT_W'(1));

  p_irq_on_change_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mon_sync != $past(mon_sync)) |-> irq);

  p_irq_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr) |=> irq);

  p_sync_on_beat_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mon_sync) |-> $past(rx_valid));

endmodule

bind prbs_test_engine prbs_test_engine_chk #(.CNT_W(ERR_CNT_W)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_q     (cfg_q),
  .irq_clr   (irq_clr),
  .cnt_clr   (cnt_clr),
  .rx_valid  (rx_valid),
  .mon_sync  (mon_sync),
  .sync_pin  (sync_pin),
  .err_count (err_count),
  .irq       (irq)
);

// File: tb/test_prbs_test_engine.sv
`timescale 1ns/1ps
module test_prbs_test_engine;

  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [3:0] cfg_wdata = '0;
  logic [3:0] cfg_q;
  logic irq_clr = 1'b0, cnt_clr = 1'b0;
  logic tx_in_valid = 1'b0, tx_in_bit = 1'b0, tx_out_ready = 1'b0;
  logic tx_in_ready, tx_out_valid, tx_out_bit;
  logic rx_valid = 1'b0, rx_bit = 1'b0, rx_ready;
  logic mon_sync, sync_pin, irq;
  logic [CW-1:0] err_count;

  int nchk = 0, nerr = 0;
  bit done = 0;
  logic [19:0] tx_s, rx_s;
  logic rx_long;

  always #10 clk = ~clk;

  prbs_test_engine #(.ERR_CNT_W(CW)) i_prbs_test_engine (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_q(cfg_q),
    .irq_clr(irq_clr), .cnt_clr(cnt_clr),
    .tx_in_valid(tx_in_valid), .tx_in_ready(tx_in_ready), .tx_in_bit(tx_in_bit),
    .tx_out_valid(tx_out_valid), .tx_out_ready(tx_out_ready), .tx_out_bit(tx_out_bit),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_bit(rx_bit),
    .mon_sync(mon_sync), .sync_pin(sync_pin), .err_count(err_count), .irq(irq)
  );

  function automatic logic ref_fb(input logic [19:0] s, input logic lng);
    return lng ? (s[19] ^ s[16]) : (s[14] ^ s[13]);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [3:0] v);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic pulse(ref logic sig);
    sig = 1'b1;
    @(negedge clk);
    sig = 1'b0;
  endtask

  task automatic rx_send(input logic flip);
    rx_valid = 1'b1;
    rx_bit = ref_fb(rx_s, rx_long) ^ flip;
    rx_s = {rx_s[18:0], ref_fb(rx_s, rx_long)};
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic rx_clean(input int n);
    for (int i = 0; i < n; i++) rx_send(1'b0);
  endtask

  task automatic rx_new_seq(input logic lng);
    rx_long = lng;
    rx_s = 20'($urandom) | 20'h1;
  endtask

  task automatic tx_beats(input int n, input logic en);
    for (int i = 0; i < n; i++) begin
      logic hs;
      tx_in_valid = ($urandom % 4) != 0;
      tx_out_ready = ($urandom % 4) != 0;
      tx_in_bit = $urandom;
      #1;
      chk("R2 out_valid", tx_out_valid, tx_in_valid);
      chk("R2 in_ready", tx_in_ready, tx_out_ready);
      if (en) chk("R3 prbs bit", tx_out_bit, ref_fb(tx_s, cfg_q[2]));
      else    chk("R2 passthrough", tx_out_bit, tx_in_bit);
      hs = tx_in_valid && tx_out_ready;
      @(negedge clk);
      if (en && hs) tx_s = {tx_s[18:0], ref_fb(tx_s, cfg_q[2])};
    end
    tx_in_valid = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 cfg", cfg_q, 0);
    chk("R1 sync", mon_sync, 0);
    chk("R1 pin", sync_pin, 0);
    chk("R1 irq", irq, 0);
    chk("R1 count", err_count, 0);
    chk("R1 rx_ready", rx_ready, 1);

    // R2 pass-through
    tx_beats(20, 1'b0);
    // R3 short then long generator, each from the all-ones seed
    cfg_write(4'h1); tx_s = '1;
    tx_beats(60, 1'b1);
    cfg_write(4'h0);
    cfg_write(4'h5); tx_s = '1;
    tx_beats(60, 1'b1);
    cfg_write(4'h0);

    // R4 all zero never syncs, then short sync bounds
    cfg_write(4'h2);
    rx_long = 1'b0; rx_s = '0;
    rx_clean(100);
    chk("R4 zeros no sync", mon_sync, 0);
    rx_new_seq(1'b0);
    rx_clean(31);
    chk("R4 no sync at 31", mon_sync, 0);
    rx_clean(16);
    chk("R4 sync by N+32", mon_sync, 1);
    chk("R10 irq on sync", irq, 1);
    pulse(irq_clr);
    chk("R10 irq cleared", irq, 0);
    chk("R11 pin gated off", sync_pin, 0);
    cfg_write(4'hA);
    chk("R11 pin on", sync_pin, 1);
    chk("R6 count clean", err_count, 0);

    // R5/R6 five errors per window keep sync and are counted
    for (int g = 0; g < 2; g++) begin
      int r = $urandom % 8;
      for (int i = 0; i < 40; i++) rx_send((i % 8) == r);
      rx_clean(70);
    end
    chk("R5 sync kept", mon_sync, 1);
    chk("R6 count 10", err_count, 10);

    // R8 clear, then clear with a same-cycle error
    pulse(cnt_clr);
    chk("R8 cleared", err_count, 0);
    cnt_clr = 1'b1;
    rx_send(1'b1);
    cnt_clr = 1'b0;
    chk("R8 clear+error", err_count, 1);

    // R5 loss on sixth error in window
    rx_clean(70);
    for (int e = 0; e < 5; e++) begin rx_send(1'b1); rx_clean(2); end
    chk("R5 sync after 5", mon_sync, 1);
    rx_send(1'b1);
    chk("R5 loss on 6th", mon_sync, 0);
    chk("R10 irq on loss", irq, 1);
    chk("R6 count 7", err_count, 7);
    chk("R11 pin follows", sync_pin, 0);
    // R6 hunting mismatches not counted
    for (int i = 0; i < 20; i++) begin
      rx_valid = 1'b1; rx_bit = $urandom; @(negedge clk);
    end
    rx_valid = 1'b0;
    chk("R6 hunt no count", err_count, 7);

    // R10 clear and event in same cycle; R9 disable
    rx_new_seq(1'b0);
    rx_clean(47);
    chk("R4 resync", mon_sync, 1);
    pulse(irq_clr);
    cfg_we = 1'b1; cfg_wdata = 4'h8;
    @(negedge clk);
    cfg_we = 1'b0; irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
    chk("R10 event beats clear", irq, 1);
    chk("R9 sync off", mon_sync, 0);
    for (int i = 0; i < 30; i++) rx_send(i % 3 == 0);
    chk("R9 count frozen", err_count, 7);
    chk("R9 still off", mon_sync, 0);

    // R4 long pattern
    cfg_write(4'h6);
    rx_new_seq(1'b1);
    rx_clean(31);
    chk("R4 long no sync at 31", mon_sync, 0);
    rx_clean(21);
    chk("R4 long sync", mon_sync, 1);

    // R7 saturation
    pulse(cnt_clr);
    for (int g = 0; g < 60; g++)
      for (int i = 0; i < 64; i++) rx_send(i < 40 && (i % 8) == 0);
    chk("R7 saturated", err_count, 255);
    chk("R5 sync held", mon_sync, 1);
    pulse(cnt_clr);
    chk("R8 final clear", err_count, 0);

    done = 1;
    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule